// File: doc/BRIEF.md
# Bracket-Loop Interpreter Core

This core runs programs written in the eight-symbol bracket-loop esoteric language directly from one word-addressed memory. The memory holds the program, the data cells and a return stack of loop-entry addresses. There is no accumulator. The only arithmetic is stepping a cell, the data pointer, the stack pointer or the program counter up or down by one.

Every instruction is handled in the same three steps. The core fetches the opcode, then reads the current cell, then executes the instruction. A taken `]` does not search backward for its partner. It reads the loop-entry address pushed by the matching `[` and jumps there. A `[` over a zero cell scans forward with a nesting counter instead. The surrounding system loads the program, sets the stack base on `sp_init` and pulses `start`. It then waits for `halt`.

Top module: `bfloop_cpu`

## Requirements
- R1: While `rst_n` is low and afterwards until `start`, `busy`, `halt`, `error` and `mem_we` are all 0.
- R2: A `start` pulse puts the program counter at PROG_BASE (0x0200), the data pointer at 0x0000, and the stack pointer and the empty-stack mark at `sp_init`. The first fetch reads PROG_BASE in the cycle after `start` is sampled. Every instruction then takes a fetch cycle, a cell-read cycle and an execute cycle, and read data is expected one cycle after its address.
- R3: Opcode 0x002B increments and 0x002D decrements the current cell, with 16-bit wraparound. The new value is written to the data-pointer address in the execute cycle. `mem_we` is never high unless `busy` is.
- R4: Opcodes 0x003E and 0x003C step the data pointer up and down. These instructions write nothing.
- R5: Opcode 0x005B over a nonzero cell first increments the stack pointer. In the execute cycle it then writes the address of the following instruction to the new stack pointer address.
- R6: Opcode 0x005B over a zero cell pushes nothing. The core then reads the following words, two cycles per word. Each nested 0x005B adds one to the depth and each 0x005D removes one. Execution resumes after the 0x005D that brings the depth to zero, and nothing is written during the scan.
- R7: Opcode 0x005D over a nonzero cell reads the top stack entry in the execute cycle. The program counter is loaded from it in one more cycle, and the stack pointer is left unchanged.
- R8: Opcode 0x005D over a zero cell writes 0x0000 to the top stack entry in the execute cycle. It then decrements the stack pointer and continues at the next instruction.
- R9: An all-zero opcode word stops the core. From the cycle after its execute cycle, `halt` is 1 and `busy` is 0, and both hold until the next `start`.
- R10: Any other opcode value takes three cycles, writes nothing and moves to the next word.
- R11: A push when the stack pointer is 0xFFFF writes nothing. Instead it sets `error` and halts.
- R12: A 0x005D while the stack pointer equals the mark taken at `start` writes nothing. It sets `error`, which stays with `halt` until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run from PROG_BASE |
| sp_init | input | 16 | Stack base loaded by `start` |
| mem_addr | output | 16 | Memory word address |
| mem_we | output | 1 | Write strobe for the addressed word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| busy | output | 1 | Core is executing |
| halt | output | 1 | Core stopped on a zero opcode or an error |
| error | output | 1 | Stack overflow or unmatched loop close |

## Verification
Cell updates, stack pushes and stack clears appear on the write port in the third cycle of their instruction. A taken loop close costs a fourth cycle, and a skipped loop costs two cycles for every word scanned. `halt` rises in the cycle after the execute cycle of a zero opcode or a faulting bracket. The bench runs each program through an interpreter that emits one expected bus entry per clock using these costs. It compares the entry with the outputs at every falling edge from the first fetch onward, so a result that comes one cycle early or late shows up as a mismatch in that cycle.

// File: rtl/bfloop_pkg.sv
package bfloop_pkg;

    localparam logic [7:0] OPC_INC   = 8'h2B;
    localparam logic [7:0] OPC_DEC   = 8'h2D;
    localparam logic [7:0] OPC_RIGHT = 8'h3E;
    localparam logic [7:0] OPC_LEFT  = 8'h3C;
    localparam logic [7:0] OPC_OPEN  = 8'h5B;
    localparam logic [7:0] OPC_CLOSE = 8'h5D;

    typedef enum logic [2:0] {
        OP_HALT, OP_INC, OP_DEC, OP_RIGHT, OP_LEFT, OP_OPEN, OP_CLOSE, OP_NOP
    } op_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DECODE, ST_EXEC, ST_LOADPC, ST_SCANF, ST_SCAND, ST_HALT
    } state_t;

endpackage

// File: rtl/bfloop_decode.sv
module bfloop_decode
    import bfloop_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] word,
    output op_t           op
);
    always_comb begin
        if (word == '0)                    op = OP_HALT;
        else if (word == DW'(OPC_INC))     op = OP_INC;
        else if (word == DW'(OPC_DEC))     op = OP_DEC;
        else if (word == DW'(OPC_RIGHT))   op = OP_RIGHT;
        else if (word == DW'(OPC_LEFT))    op = OP_LEFT;
        else if (word == DW'(OPC_OPEN))    op = OP_OPEN;
        else if (word == DW'(OPC_CLOSE))   op = OP_CLOSE;
        else                               op = OP_NOP;
    end
endmodule

// File: rtl/bfloop_step.sv
module bfloop_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic         down,
    output logic [W-1:0] y
);
    always_comb y = down ? (a - W'(1)) : (a + W'(1));
endmodule

// File: rtl/bfloop_cpu.sv
module bfloop_cpu
    import bfloop_pkg::*;
#(
    parameter int             AW        = 16,
    parameter int             DW        = 16,
    parameter int             DEPTH_W   = 16,
    parameter logic [AW-1:0]  PROG_BASE = 16'h0200,
    parameter logic [AW-1:0]  SP_RESET  = 16'h00FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] sp_init,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          halt,
    output logic          error
);
    typedef struct packed {
        state_t             st;
        op_t                op;
        logic [AW-1:0]      pc;
        logic [AW-1:0]      dp;
        logic [AW-1:0]      sp;
        logic [AW-1:0]      base;
        logic [DEPTH_W-1:0] depth;
        logic               err;
    } regs_t;

    regs_t r_q, r_d;

    op_t           dec_op;
    logic [DW-1:0] cell_nx;
    logic [AW-1:0] dp_nx, sp_up, sp_dn, pc_inc;
    logic          cell_zero;

    bfloop_decode #(.DW(DW)) u_dec (.word(mem_rdata), .op(dec_op));

    bfloop_step #(.W(DW)) u_cell  (.a(mem_rdata), .down(r_q.op == OP_DEC),  .y(cell_nx));
    bfloop_step #(.W(AW)) u_dp    (.a(r_q.dp),    .down(r_q.op == OP_LEFT), .y(dp_nx));
    bfloop_step #(.W(AW)) u_sp_up (.a(r_q.sp),    .down(1'b0),              .y(sp_up));
    bfloop_step #(.W(AW)) u_sp_dn (.a(r_q.sp),    .down(1'b1),              .y(sp_dn));
    bfloop_step #(.W(AW)) u_pc    (.a(r_q.pc),    .down(1'b0),              .y(pc_inc));

    assign cell_zero = (mem_rdata == '0);

    always_comb begin
        r_d       = r_q;
        mem_addr  = r_q.dp;
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (r_q.st)
            ST_FETCH: begin
                mem_addr = r_q.pc;
                r_d.st   = ST_DECODE;
            end
            ST_DECODE: begin
                r_d.op = dec_op;
                r_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                r_d.st = ST_FETCH;
                r_d.pc = pc_inc;
                case (r_q.op)
                    OP_HALT: begin
                        r_d.pc = r_q.pc;
                        r_d.st = ST_HALT;
                    end
                    OP_INC, OP_DEC: begin
                        mem_we    = 1'b1;
                        mem_wdata = cell_nx;
                    end
                    OP_RIGHT, OP_LEFT: r_d.dp = dp_nx;
                    OP_OPEN: begin
                        if (cell_zero) begin
                            r_d.depth = DEPTH_W'(1);
                            r_d.st    = ST_SCANF;
                        end else if (r_q.sp == '1) begin
                            r_d.pc  = r_q.pc;
                            r_d.err = 1'b1;
                            r_d.st  = ST_HALT;
                        end else begin
                            r_d.sp    = sp_up;
                            mem_addr  = sp_up;
                            mem_we    = 1'b1;
                            mem_wdata = DW'(pc_inc);
                        end
                    end
                    OP_CLOSE: begin
                        if (r_q.sp == r_q.base) begin
                            r_d.pc  = r_q.pc;
                            r_d.err = 1'b1;
                            r_d.st  = ST_HALT;
                        end else if (!cell_zero) begin
                            r_d.pc   = r_q.pc;
                            mem_addr = r_q.sp;
                            r_d.st   = ST_LOADPC;
                        end else begin
                            mem_addr  = r_q.sp;
                            mem_we    = 1'b1;
                            mem_wdata = '0;
                            r_d.sp    = sp_dn;
                        end
                    end
                    default: ;
                endcase
            end
            ST_LOADPC: begin
                r_d.pc = AW'(mem_rdata);
                r_d.st = ST_FETCH;
            end
            ST_SCANF: begin
                mem_addr = r_q.pc;
                r_d.st   = ST_SCAND;
            end
            ST_SCAND: begin
                r_d.pc = pc_inc;
                r_d.st = ST_SCANF;
                if (dec_op == OP_OPEN) begin
                    r_d.depth = r_q.depth + DEPTH_W'(1);
                end else if (dec_op == OP_CLOSE) begin
                    r_d.depth = r_q.depth - DEPTH_W'(1);
                    if (r_q.depth == DEPTH_W'(1)) r_d.st = ST_FETCH;
                end
            end
            default: ;
        endcase

        if (start) begin
            r_d.st    = ST_FETCH;
            r_d.pc    = PROG_BASE;
            r_d.dp    = '0;
            r_d.sp    = sp_init;
            r_d.base  = sp_init;
            r_d.depth = '0;
            r_d.err   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, op: OP_NOP, pc: PROG_BASE, dp: '0,
                     sp: SP_RESET, base: SP_RESET, depth: '0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy  = (r_q.st != ST_IDLE) && (r_q.st != ST_HALT);
    assign halt  = (r_q.st == ST_HALT);
    assign error = r_q.err;

endmodule

// File: rtl/bfloop_cpu_chk.sv
module bfloop_cpu_chk #(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] PROG_BASE = 16'h0200
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          busy,
    input logic          halt,
    input logic          error
);
    AST_FIRST_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (mem_addr == PROG_BASE && !mem_we));           // R2
    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);                                               // R3
    AST_HALT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !busy);                                                // R9
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !start) |=> halt);                                     // R9
    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> halt);                                                // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);                                   // R12
endmodule

bind bfloop_cpu bfloop_cpu_chk #(.AW(AW), .PROG_BASE(PROG_BASE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .busy     (busy),
    .halt     (halt),
    .error    (error)
);

// File: tb/bfloop_cpu_bench.sv
module bfloop_cpu_bench;
    localparam time CLK_P = 20ns;
    localparam logic [15:0] BASE = 16'h0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] sp_init = 16'h00FF;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        busy, halt, error;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    bfloop_cpu u_bfloop_cpu (
        .clk(clk), .rst_n(rst_n), .start(start), .sp_init(sp_init),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .halt(halt), .error(error)
    );

    // memory seen by the core, and the model's private copy
    logic [15:0] dmem [logic [15:0]];
    logic [15:0] mmem [logic [15:0]];

    function automatic logic [15:0] rd_d(logic [15:0] a);
        return dmem.exists(a) ? dmem[a] : 16'h0000;
    endfunction
    function automatic logic [15:0] rd_m(logic [15:0] a);
        return mmem.exists(a) ? mmem[a] : 16'h0000;
    endfunction

    always @(posedge clk) begin
        mem_rdata <= rd_d(mem_addr);
        if (mem_we) dmem[mem_addr] = mem_wdata;
    end

    typedef struct {
        bit          we;
        logic [15:0] a;
        logic [15:0] d;
        string       tag;
    } cyc_t;

    cyc_t exp_q[$];
    bit   exp_err;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void put(bit we, logic [15:0] a, logic [15:0] d, string tag);
        cyc_t c;
        c.we = we; c.a = a; c.d = d; c.tag = tag;
        exp_q.push_back(c);
    endfunction

    // instruction-level interpreter that emits one entry per clock
    task automatic model_run(logic [15:0] spi);
        logic [15:0] pc, dp, sp, bs, op, c, o;
        int d;
        pc = BASE; dp = 0; sp = spi; bs = spi;
        exp_q.delete(); exp_err = 0;
        for (int step = 0; step < 5000; step++) begin
            op = rd_m(pc);
            put(0, 0, 0, "R2"); put(0, 0, 0, "R2");
            c = rd_m(dp);
            case (op)
                16'h0000: begin put(0, 0, 0, "R9"); return; end
                16'h002B: begin put(1, dp, c + 1, "R3"); mmem[dp] = c + 1; pc++; end
                16'h002D: begin put(1, dp, c - 1, "R3"); mmem[dp] = c - 1; pc++; end
                16'h003E: begin put(0, 0, 0, "R4"); dp++; pc++; end
                16'h003C: begin put(0, 0, 0, "R4"); dp--; pc++; end
                16'h005B: begin
                    if (c != 0) begin
                        if (sp == 16'hFFFF) begin put(0, 0, 0, "R11"); exp_err = 1; return; end
                        sp++; put(1, sp, pc + 1, "R5"); mmem[sp] = pc + 1; pc++;
                    end else begin
                        put(0, 0, 0, "R6"); pc++; d = 1;
                        while (d > 0) begin
                            o = rd_m(pc);
                            put(0, 0, 0, "R6"); put(0, 0, 0, "R6");
                            if (o == 16'h005B) d++;
                            else if (o == 16'h005D) d--;
                            pc++;
                        end
                    end
                end
                16'h005D: begin
                    if (sp == bs) begin put(0, 0, 0, "R12"); exp_err = 1; return; end
                    if (c != 0) begin
                        put(0, 0, 0, "R7"); put(0, 0, 0, "R7"); pc = rd_m(sp);
                    end else begin
                        put(1, sp, 0, "R8"); mmem[sp] = 0; sp--; pc++;
                    end
                end
                default: begin put(0, 0, 0, "R10"); pc++; end
            endcase
        end
    endtask

    task automatic load(string prog);
        dmem.delete(); mmem.delete();
        for (int i = 0; i < prog.len(); i++) begin
            dmem[BASE + 16'(i)] = 16'(prog[i]);
            mmem[BASE + 16'(i)] = 16'(prog[i]);
        end
    endtask

    task automatic run(string prog, logic [15:0] spi);
        cyc_t c;
        load(prog);
        model_run(spi);
        @(negedge clk);
        sp_init = spi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i > 0) @(negedge clk);
            c = exp_q[i];
            check(busy && !halt && !error, c.tag, "busy/halt/error while running",
                  {29'd0, busy, halt, error}, 32'h4);
            check(mem_we == c.we, c.tag, "write strobe", 32'(mem_we), 32'(c.we));
            if (c.we && mem_we)
                check(mem_addr == c.a && mem_wdata == c.d, c.tag, "write addr/data",
                      {mem_addr, mem_wdata}, {c.a, c.d});
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(halt && !busy && !mem_we && error == exp_err, exp_err ? "R12" : "R9",
                  "halted state", {28'd0, halt, busy, mem_we, error}, {28'd0, 1'b1, 1'b0, 1'b0, exp_err});
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !halt && !error && !mem_we, "R1", "reset outputs",
              {28'd0, busy, halt, error, mem_we}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !halt && !error && !mem_we, "R1", "idle before start",
              {28'd0, busy, halt, error, mem_we}, 32'd0);

        // nested loops, forward skip over nested brackets, unknown opcodes, wrap
        run("+++[>++[>+<-]<-]>>>[[-]+]x.>-", 16'h00FF);
        check(rd_d(16'h0002) == 16'd6, "R7", "cell 2 after nested loops", rd_d(16'h0002), 16'd6);
        check(rd_d(16'h0000) == 16'd0, "R8", "cell 0 after loops", rd_d(16'h0000), 16'd0);
        check(rd_d(16'h0100) == 16'd0 && rd_d(16'h0101) == 16'd0, "R8", "stack entries cleared",
              {rd_d(16'h0100), rd_d(16'h0101)}, 32'd0);
        check(rd_d(16'h0003) == 16'd0, "R6", "skipped loop left cell 3", rd_d(16'h0003), 16'd0);
        check(rd_d(16'h0004) == 16'hFFFF, "R3", "decrement wraps", rd_d(16'h0004), 16'hFFFF);

        // moves in both directions and a no-op run
        run(">>+<+<<+ab>>", 16'h0080);
        check(rd_d(16'h0001) == 16'd1 && rd_d(16'hFFFF) == 16'd1, "R4", "pointer steps",
              {rd_d(16'h0001), rd_d(16'hFFFF)}, {16'd1, 16'd1});
        check(rd_d(16'h0061) == 16'h0000, "R10", "unknown opcode wrote nothing", rd_d(16'h0061), 16'd0);

        // unmatched close on an empty stack
        run("+]+", 16'h00FF);
        check(rd_d(16'h0000) == 16'd1, "R12", "no write after faulting close", rd_d(16'h0000), 16'd1);

        // overflow: first push lands at 0xFFFF, second one faults
        run("+[[+", 16'hFFFE);
        check(rd_d(16'hFFFF) == BASE + 16'd2, "R11", "last legal push", rd_d(16'hFFFF), BASE + 16'd2);
        check(rd_d(16'h0000) == 16'd1, "R11", "no write after overflow", rd_d(16'h0000), 16'd1);

        // restart after an error clears the flag
        run("+[-]", 16'h00FF);
        check(rd_d(16'h0100) == 16'd0, "R5", "pushed entry cleared on exit", rd_d(16'h0100), 16'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule